// File: doc/BRIEF.md
# Event Frame Formatter with Parity

This block builds one fixed-length event frame for a serial link transmitter each time it is started. Every frame opens with a control-flagged all-ones word and closes with a control-flagged all-zeros word. Between them come five header words, a data section, and six trailer words. The header words are detector ID, event number, module address, flag word and beam-crossing count. The data section is built from two 10-bit readout streams. The trailer words are two user words, a status word, an all-zeros word, a parity word and the closing delimiter.

Each data word joins one 10-bit word from each source, both taken in the same clock. The block tells the sources which channel and which board it is collecting. The order runs through every channel in ascending order. Within a channel, a block of words comes from the first board and then the same number from the second board. When either source has no word ready, the formatter waits. During the wait it emits nothing and its parity does not move.

An event counter inside the block advances once per finished frame. A beam-crossing counter inside the block counts tick pulses and is sampled when a frame starts. With the defaults (40 channels, 12 words per board), a frame is 972 words long.

Top module: `efp_formatter`

## Requirements
- R1: During and right after reset, out_word is zero, out_cav and out_dav are low, and both source ready outputs are low.
- R2: The first word of a frame is all ones and the last is all zeros. Both carry out_cav=1 and out_dav=0.
- R3: A frame emits exactly 6 + NUM_CHAN*2*WPB + 6 flagged words (972 by default) and then goes quiet. A start pulse while a frame is in progress has no effect.
- R4: Words 2, 4 and 5 are cfg_det_id, cfg_mod_addr and cfg_flag.
- R5: Each data word is {src_b_data, src_a_data}, with source A in bits 9:0. Both ready outputs rise together, and only when both valids are high.
- R6: Data is collected with req_chan ascending from 0. In each channel, WPB words come with req_board=0 and then WPB words with req_board=1.
- R7: After the data come cfg_user1, cfg_user2, status_word and an all-zeros word, in that order.
- R8: The second-to-last word is the bitwise XOR of words 2 through third-to-last.
- R9: Every word other than the two delimiters carries out_dav=1 and out_cav=0. No cycle has both flags high.
- R10: Word 3 is the event number, zero-extended from EVT_W bits (16 by default). It is 0 in the first frame after reset, adds 1 per completed frame and wraps.
- R11: While collecting data with either source not valid, no word is emitted and the parity accumulator holds.
- R12: Word 6 is a BEAM_W-bit (8 by default) count of beam_tick pulses since reset, wrapping, sampled in the cycle the start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame (accepted when idle) |
| beam_tick | input | 1 | One beam crossing |
| cfg_det_id | input | 20 | Detector ID word |
| cfg_mod_addr | input | 20 | Module address word |
| cfg_flag | input | 20 | Flag word |
| cfg_user1 | input | 20 | First user word |
| cfg_user2 | input | 20 | Second user word |
| status_word | input | 20 | Status word |
| src_a_data | input | 10 | Source A readout word |
| src_a_valid | input | 1 | Source A word available |
| src_a_ready | output | 1 | Source A word taken this cycle |
| src_b_data | input | 10 | Source B readout word |
| src_b_valid | input | 1 | Source B word available |
| src_b_ready | output | 1 | Source B word taken this cycle |
| req_chan | output | 6 | Channel being collected |
| req_board | output | 1 | Board being collected (0 first) |
| out_word | output | 20 | Frame word |
| out_cav | output | 1 | Control word flag |
| out_dav | output | 1 | Data word flag |

## Verification
Every frame of a reduced configuration is checked word by word against a frame built arithmetically in the bench. Source availability is varied across frames: both sources always ready, A every other cycle, B every third cycle, and sparse interleaved availability. These patterns separate a formatter that stalls correctly from one that emits stale halves, takes the two sources apart, or folds stalled cycles into parity. A narrowed event counter run over ten frames exposes a wrong increment point or a missing wrap. A start pulse in the middle of a frame, and hundreds of beam ticks before a start, show whether frame length and the sampled beam count hold.

// File: rtl/efp_pkg.sv
package efp_pkg;
    localparam int HDR_WORDS = 6;
    localparam int TRL_WORDS = 6;

    function automatic int frame_len(input int nch, input int wpb);
        return HDR_WORDS + nch * 2 * wpb + TRL_WORDS;
    endfunction
endpackage

// File: rtl/efp_counters.sv
module efp_counters #(
    parameter int EVT_W  = 16,
    parameter int BEAM_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beam_tick,
    input  logic              frame_start,
    input  logic              frame_done,
    output logic [EVT_W-1:0]  evt_num,
    output logic [BEAM_W-1:0] beam_snap
);
    typedef struct packed {
        logic [EVT_W-1:0]  evt;
        logic [BEAM_W-1:0] beam;
        logic [BEAM_W-1:0] snap;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (beam_tick)   cnt_d.beam = cnt_q.beam + 1'b1;
        if (frame_start) cnt_d.snap = cnt_q.beam;
        if (frame_done)  cnt_d.evt  = cnt_q.evt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign evt_num   = cnt_q.evt;
    assign beam_snap = cnt_q.snap;

    // R10: one step per finished frame, wrapping
    p_evt_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> cnt_q.evt == EVT_W'($past(cnt_q.evt) + 1'b1));

    // R12: beam count moves only on a tick
    p_beam_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !beam_tick |=> $stable(cnt_q.beam));
endmodule

// File: rtl/efp_seq.sv
module efp_seq #(
    parameter int NUM_CHAN = 40,
    parameter int WPB      = 12,
    parameter int FLEN     = 972,
    parameter int IDX_W    = 10,
    parameter int CHAN_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              adv,
    output logic              busy,
    output logic [IDX_W-1:0]  idx,
    output logic [CHAN_W-1:0] chan,
    output logic              board,
    output logic              in_data,
    output logic              last
);
    import efp_pkg::*;

    localparam int WCNT_W   = (WPB > 1) ? $clog2(WPB) : 1;
    localparam int DATA_END = HDR_WORDS + NUM_CHAN * 2 * WPB;

    typedef struct packed {
        logic              busy;
        logic [IDX_W-1:0]  idx;
        logic [CHAN_W-1:0] chan;
        logic              board;
        logic [WCNT_W-1:0] wcnt;
    } seq_t;

    seq_t s_d, s_q;

    assign busy    = s_q.busy;
    assign idx     = s_q.idx;
    assign chan    = s_q.chan;
    assign board   = s_q.board;
    assign in_data = s_q.busy && (s_q.idx >= IDX_W'(HDR_WORDS)) && (s_q.idx < IDX_W'(DATA_END));
    assign last    = s_q.busy && (s_q.idx == IDX_W'(FLEN - 1));

    always_comb begin
        s_d = s_q;
        if (!s_q.busy) begin
            if (start) begin
                s_d      = '0;
                s_d.busy = 1'b1;
            end
        end else if (adv) begin
            s_d.idx = s_q.idx + 1'b1;
            if (in_data) begin
                if (s_q.wcnt == WCNT_W'(WPB - 1)) begin
                    s_d.wcnt = '0;
                    if (s_q.board) begin
                        s_d.board = 1'b0;
                        s_d.chan  = s_q.chan + 1'b1;
                    end else begin
                        s_d.board = 1'b1;
                    end
                end else begin
                    s_d.wcnt = s_q.wcnt + 1'b1;
                end
            end
            if (last) s_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R3: position stays inside the frame
    p_idx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |-> s_q.idx < IDX_W'(FLEN));

    // R3: a start during a frame does not restart it
    p_start_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !last && start) |=> s_q.busy && s_q.idx != '0);

    // R6: channel stays in range while collecting
    p_chan_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_data |-> s_q.chan < CHAN_W'(NUM_CHAN));
endmodule

// File: rtl/efp_formatter.sv
module efp_formatter #(
    parameter int NUM_CHAN = 40,
    parameter int WPB      = 12,
    parameter int HALF_W   = 10,
    parameter int EVT_W    = 16,
    parameter int BEAM_W   = 8,
    parameter int CHAN_W   = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                beam_tick,
    input  logic [2*HALF_W-1:0] cfg_det_id,
    input  logic [2*HALF_W-1:0] cfg_mod_addr,
    input  logic [2*HALF_W-1:0] cfg_flag,
    input  logic [2*HALF_W-1:0] cfg_user1,
    input  logic [2*HALF_W-1:0] cfg_user2,
    input  logic [2*HALF_W-1:0] status_word,
    input  logic [HALF_W-1:0]   src_a_data,
    input  logic                src_a_valid,
    output logic                src_a_ready,
    input  logic [HALF_W-1:0]   src_b_data,
    input  logic                src_b_valid,
    output logic                src_b_ready,
    output logic [CHAN_W-1:0]   req_chan,
    output logic                req_board,
    output logic [2*HALF_W-1:0] out_word,
    output logic                out_cav,
    output logic                out_dav
);
    import efp_pkg::*;

    localparam int WORD_W   = 2 * HALF_W;
    localparam int FLEN     = frame_len(NUM_CHAN, WPB);
    localparam int IDX_W    = $clog2(FLEN + 1);
    localparam int DATA_END = HDR_WORDS + NUM_CHAN * 2 * WPB;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              cav;
        logic              dav;
        logic [WORD_W-1:0] par;
    } fmt_t;

    fmt_t r_d, r_q;

    logic              busy, in_data, last, adv, both_ok, accept;
    logic [IDX_W-1:0]  idx, toff;
    logic [EVT_W-1:0]  evt_num;
    logic [BEAM_W-1:0] beam_snap;
    logic [WORD_W-1:0] cur;
    logic              cur_ctl;

    assign both_ok     = src_a_valid && src_b_valid;
    assign adv         = busy && (!in_data || both_ok);
    assign accept      = start && !busy;
    assign src_a_ready = in_data && both_ok;
    assign src_b_ready = in_data && both_ok;

    efp_seq #(
        .NUM_CHAN (NUM_CHAN),
        .WPB      (WPB),
        .FLEN     (FLEN),
        .IDX_W    (IDX_W),
        .CHAN_W   (CHAN_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .adv     (adv),
        .busy    (busy),
        .idx     (idx),
        .chan    (req_chan),
        .board   (req_board),
        .in_data (in_data),
        .last    (last)
    );

    efp_counters #(
        .EVT_W  (EVT_W),
        .BEAM_W (BEAM_W)
    ) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .beam_tick   (beam_tick),
        .frame_start (accept),
        .frame_done  (last && adv),
        .evt_num     (evt_num),
        .beam_snap   (beam_snap)
    );

    assign toff = idx - IDX_W'(DATA_END);

    // word selection for the current position
    always_comb begin
        cur     = '0;
        cur_ctl = 1'b0;
        if (idx == '0) begin
            cur     = '1;
            cur_ctl = 1'b1;
        end else if (idx < IDX_W'(HDR_WORDS)) begin
            case (idx)
                IDX_W'(1): cur = cfg_det_id;
                IDX_W'(2): cur = WORD_W'(evt_num);
                IDX_W'(3): cur = cfg_mod_addr;
                IDX_W'(4): cur = cfg_flag;
                default:   cur = WORD_W'(beam_snap);
            endcase
        end else if (in_data) begin
            cur = {src_b_data, src_a_data};
        end else begin
            case (toff)
                IDX_W'(0): cur = cfg_user1;
                IDX_W'(1): cur = cfg_user2;
                IDX_W'(2): cur = status_word;
                IDX_W'(3): cur = '0;
                IDX_W'(4): cur = r_q.par;
                default: begin
                    cur     = '0;
                    cur_ctl = 1'b1;
                end
            endcase
        end
    end

    always_comb begin
        r_d     = r_q;
        r_d.cav = 1'b0;
        r_d.dav = 1'b0;
        if (accept) r_d.par = '0;
        if (adv) begin
            r_d.word = cur;
            r_d.cav  = cur_ctl;
            r_d.dav  = !cur_ctl;
            if (idx != '0 && idx < IDX_W'(FLEN - 2)) r_d.par = r_q.par ^ cur;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign out_word = r_q.word;
    assign out_cav  = r_q.cav;
    assign out_dav  = r_q.dav;

    // R2, R9: a control word is a delimiter value and never data
    p_delim_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_cav |-> !out_dav && (out_word == '1 || out_word == '0));

    // R11: a stalled data cycle emits nothing and parity holds
    p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && !both_ok) |=> $stable(r_q.par) && !out_dav && !out_cav);

    // R5: both sources are taken together and only when both offer
    p_ready_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        src_a_ready |-> src_b_ready && src_a_valid && src_b_valid);
endmodule

// File: tb/efp_formatter_test.sv
module efp_formatter_test;
    localparam int NCH   = 3;
    localparam int WPB   = 2;
    localparam int EVTW  = 3;
    localparam int FLEN  = 6 + NCH * 2 * WPB + 6;
    localparam int NDATA = NCH * 2 * WPB;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        beam_tick = 1'b0;
    logic [19:0] cfg_det_id = '0, cfg_mod_addr = '0, cfg_flag = '0;
    logic [19:0] cfg_user1 = '0, cfg_user2 = '0, status_word = '0;
    logic [9:0]  src_a_data = '0, src_b_data = '0;
    logic        src_a_valid = 1'b0, src_b_valid = 1'b0;
    logic        src_a_ready, src_b_ready;
    logic [1:0]  req_chan;
    logic        req_board;
    logic [19:0] out_word;
    logic        out_cav, out_dav;

    int checks = 0;
    int failures = 0;
    logic [EVTW-1:0] evt_model = '0;
    logic [7:0]      beam_model = '0;
    logic [19:0]     exp_w [FLEN];

    always #10 clk = ~clk;

    efp_formatter #(
        .NUM_CHAN (NCH),
        .WPB      (WPB),
        .HALF_W   (10),
        .EVT_W    (EVTW),
        .BEAM_W   (8)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .beam_tick(beam_tick),
        .cfg_det_id(cfg_det_id), .cfg_mod_addr(cfg_mod_addr), .cfg_flag(cfg_flag),
        .cfg_user1(cfg_user1), .cfg_user2(cfg_user2), .status_word(status_word),
        .src_a_data(src_a_data), .src_a_valid(src_a_valid), .src_a_ready(src_a_ready),
        .src_b_data(src_b_data), .src_b_valid(src_b_valid), .src_b_ready(src_b_ready),
        .req_chan(req_chan), .req_board(req_board),
        .out_word(out_word), .out_cav(out_cav), .out_dav(out_dav)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(input int i);
        if (i == 0 || i == FLEN - 1) return "R2";
        if (i == 2) return "R10";
        if (i == 5) return "R12";
        if (i < 6) return "R4";
        if (i < 6 + NDATA) return "R5";
        if (i == FLEN - 2) return "R8";
        return "R7";
    endfunction

    function automatic logic [9:0] a_of(input int k, input int salt);
        return 10'(k * 37 + salt * 11 + 3);
    endfunction

    function automatic logic [9:0] b_of(input int k, input int salt);
        return 10'(k * 91 + salt * 5 + 500);
    endfunction

    function automatic logic a_ok(input int mode, input int cyc);
        case (mode)
            1: return (cyc % 2) == 0;
            3: return (cyc % 4) == 1;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic b_ok(input int mode, input int cyc);
        case (mode)
            2: return (cyc % 3) == 0;
            3: return (cyc % 2) == 1;
            default: return 1'b1;
        endcase
    endfunction

    task automatic run_frame(input int mode, input int ticks, input int salt, input bit mid_start);
        int nw = 0;
        int k = 0;
        int cyc = 0;
        logic [19:0] par;
        for (int t = 0; t < ticks; t++) begin
            @(negedge clk); beam_tick = 1'b1;
            @(negedge clk); beam_tick = 1'b0;
            beam_model = beam_model + 8'd1;
        end
        cfg_det_id   = 20'(32'h1A5C3 + salt * 7);
        cfg_mod_addr = 20'(32'h0F00D + salt * 13);
        cfg_flag     = 20'(32'h55AA5 ^ salt);
        cfg_user1    = 20'(32'h12345 + salt);
        cfg_user2    = 20'(32'hABCDE - salt);
        status_word  = 20'(32'h70707 + salt * 3);
        exp_w[0] = '1;
        exp_w[1] = cfg_det_id;
        exp_w[2] = 20'(evt_model);
        exp_w[3] = cfg_mod_addr;
        exp_w[4] = cfg_flag;
        exp_w[5] = 20'(beam_model);
        for (int d = 0; d < NDATA; d++) exp_w[6 + d] = {b_of(d, salt), a_of(d, salt)};
        exp_w[6 + NDATA]     = cfg_user1;
        exp_w[7 + NDATA]     = cfg_user2;
        exp_w[8 + NDATA]     = status_word;
        exp_w[9 + NDATA]     = '0;
        par = '0;
        for (int i = 1; i <= FLEN - 3; i++) par = par ^ exp_w[i];
        exp_w[FLEN - 2] = par;
        exp_w[FLEN - 1] = '0;

        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (nw < FLEN && cyc < 2000) begin
            // outputs from the last edge
            if (out_cav || out_dav) begin
                check("R9", "both flags", int'(out_cav && out_dav), 0);
                check(tag_of(nw), $sformatf("word %0d", nw), int'(out_word), int'(exp_w[nw]));
                check(nw == 0 || nw == FLEN - 1 ? "R2" : "R9", $sformatf("cav at word %0d", nw),
                      int'(out_cav), int'(nw == 0 || nw == FLEN - 1));
                nw++;
            end
            // R3: start mid-frame must be ignored
            start = mid_start && (cyc == 10);
            if (k < NDATA) begin
                src_a_valid = a_ok(mode, cyc);
                src_b_valid = b_ok(mode, cyc);
                src_a_data  = a_of(k, salt);
                src_b_data  = b_of(k, salt);
            end else begin
                src_a_valid = 1'b1;
                src_b_valid = 1'b1;
            end
            #1;
            if (src_a_ready || src_b_ready) begin
                check("R5", "ready pair", int'({src_a_ready, src_b_ready}), 3);
                check("R5", "ready needs valids", int'(src_a_valid && src_b_valid), 1);
                check("R6", "req_chan", int'(req_chan), k / (2 * WPB));
                check("R6", "req_board", int'(req_board), (k / WPB) % 2);
                k++;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        src_a_valid = 1'b0;
        src_b_valid = 1'b0;
        check("R3", "words in frame", nw, FLEN);
        check("R11", "data words taken", k, NDATA);
        for (int q = 0; q < 8; q++) begin
            check("R3", "quiet after frame", int'(out_cav || out_dav), 0);
            @(negedge clk);
        end
        evt_model = evt_model + 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "out_word", int'(out_word), 0);
        check("R1", "flags", int'({out_cav, out_dav}), 0);
        check("R1", "ready", int'({src_a_ready, src_b_ready}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "idle after reset", int'({out_cav, out_dav}), 0);
        for (int f = 0; f < 10; f++) begin
            run_frame(f % 4, (f == 4) ? 300 : f, f + 1, f == 2);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule